// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block keeps wall-clock time as a free-running 32-bit count of seconds, driven by a slow clock that arrives as a one-cycle tick enable in the system clock domain. A programmable prescaler sets how many slow ticks make one second. It holds the value ticks-per-second minus one. Each completed second advances the seconds count and raises a sticky once-per-second event. A 32-bit alarm compare value raises a second sticky event when the count reaches it.

Software reaches the block through a simple memory-mapped register port. The port takes a single-cycle write strobe, and read data is combinational from the address. The control word holds a run bit, an alarm arm bit and two interrupt enables. It also holds the two event flags, which software clears by writing 0 and preserves by writing 1. A plain 32-bit scratch word lets software leave a marker, such as 0x12345678, showing that the time has been set. The interrupt line is high whenever an enabled event flag is set.

Top module: `sec_rtc_core`

## Requirements
- R1: After reset, the read values are as follows. Control reads 0x00000080. Seconds, alarm and scratch read 0. The prescaler reads the parameter PRESC_RST (default 32767).
- R2: The register offsets are fixed: control at 0x00, seconds at 0x04, alarm at 0x08, prescaler at 0x0C and scratch at 0x34. While the run bit is set, the seconds count increases by 1 once every (prescaler + 1) tick enables. It wraps from 0xFFFFFFFF to 0.
- R3: While the run bit (control bit 0) is 0, tick enables change neither the seconds count nor the prescaler phase.
- R4: Every seconds increment sets the once-per-second flag (control bit 6).
- R5: The alarm flag (control bit 4) sets on an increment whose new seconds value equals the alarm register, and only if alarm arm (control bit 2) is 1.
- R6: A control write sets the arm bit and the enable bits (bits 0, 2, 3, 5) from the written data. Writing 0 to a flag bit clears that flag and writing 1 leaves it unchanged. An event in the same cycle sets the flag regardless of the write.
- R7: The interrupt output is high exactly when the alarm flag and its enable (bit 3) are both set, or when the once-per-second flag and its enable (bit 5) are both set.
- R8: The scratch register stores any 32-bit value written to it and holds it until the next write to it.
- R9: Control bit 7 (write ready) always reads 1. Control bit 1 and bits 31:8 read 0. Unmapped offsets read 0.
- R10: A write to the seconds register restarts the prescaler phase, so the next increment follows a full (prescaler + 1) ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per slow clock tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that no register write lands in the same cycle as a tick enable. Under that condition, a rising flag always coincides with a seconds change, and a rising alarm flag always sees the alarm value that caused it. The stimulus keeps within this by issuing ticks and bus writes only in separate cycles. A behavioural model in the bench follows every clock and predicts the interrupt and each read-back value. The scenarios cover several cases: prescaler phase restart, counter wrap, halting with the run bit off, alarm with and without arm, and flag preservation on a write of 1.

// File: rtl/sec_rtc_core.sv
module sec_rtc_core #(
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] PRESC_RST = 32'd32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_SECS  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_ALARM = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_PRESC = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_SCR   = ADDR_W'('h34);

  logic        run_q, arm_q, alm_ie_q, hz_ie_q;
  logic        alm_flag_q, hz_flag_q;
  logic [31:0] secs_q, alarm_q, presc_q, pcnt_q, scratch_q;

  logic wr_ctrl, wr_secs, wr_alarm, wr_presc, wr_scr;
  assign wr_ctrl  = bus_wr && bus_addr == OFS_CTRL;
  assign wr_secs  = bus_wr && bus_addr == OFS_SECS;
  assign wr_alarm = bus_wr && bus_addr == OFS_ALARM;
  assign wr_presc = bus_wr && bus_addr == OFS_PRESC;
  assign wr_scr   = bus_wr && bus_addr == OFS_SCR;

  logic        slow_step, sec_step, alm_hit;
  logic [31:0] secs_inc;
  assign slow_step = run_q & tick_en;
  assign sec_step  = slow_step & (pcnt_q >= presc_q);
  assign secs_inc  = secs_q + 32'd1;
  assign alm_hit   = sec_step & arm_q & (secs_inc == alarm_q);

  always_ff @(posedge clk) begin
    if (!rst_n)              pcnt_q <= '0;
    else if (wr_secs)        pcnt_q <= '0;
    else if (slow_step)      pcnt_q <= sec_step ? 32'd0 : pcnt_q + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              secs_q <= '0;
    else if (wr_secs)        secs_q <= bus_wdata;
    else if (sec_step)       secs_q <= secs_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q   <= '0;
      presc_q   <= PRESC_RST;
      scratch_q <= '0;
    end else begin
      if (wr_alarm) alarm_q   <= bus_wdata;
      if (wr_presc) presc_q   <= bus_wdata;
      if (wr_scr)   scratch_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      arm_q      <= 1'b0;
      alm_ie_q   <= 1'b0;
      hz_ie_q    <= 1'b0;
      alm_flag_q <= 1'b0;
      hz_flag_q  <= 1'b0;
    end else if (wr_ctrl) begin
      run_q      <= bus_wdata[0];
      arm_q      <= bus_wdata[2];
      alm_ie_q   <= bus_wdata[3];
      hz_ie_q    <= bus_wdata[5];
      alm_flag_q <= (alm_flag_q & bus_wdata[4]) | alm_hit;
      hz_flag_q  <= (hz_flag_q & bus_wdata[6]) | sec_step;
    end else begin
      alm_flag_q <= alm_flag_q | alm_hit;
      hz_flag_q  <= hz_flag_q | sec_step;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = {24'd0, 1'b1, hz_flag_q, hz_ie_q, alm_flag_q,
                              alm_ie_q, arm_q, 1'b0, run_q};
      OFS_SECS:  bus_rdata = secs_q;
      OFS_ALARM: bus_rdata = alarm_q;
      OFS_PRESC: bus_rdata = presc_q;
      OFS_SCR:   bus_rdata = scratch_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = (alm_flag_q & alm_ie_q) | (hz_flag_q & hz_ie_q);

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              run,
  input logic              arm,
  input logic              alm_flag,
  input logic              hz_flag,
  input logic [31:0]       secs,
  input logic [31:0]       alarm,
  input logic [31:0]       scratch
);

  logic w_ctrl, w_secs, w_scr;
  assign w_ctrl = bus_wr && bus_addr == ADDR_W'('h00);
  assign w_secs = bus_wr && bus_addr == ADDR_W'('h04);
  assign w_scr  = bus_wr && bus_addr == ADDR_W'('h34);

  // R2
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !w_secs |=> (secs == $past(secs)) || (secs == $past(secs) + 32'd1));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !w_secs) |=> $stable(secs));

  // R4
  hz_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hz_flag) |-> secs != $past(secs));

  // R5
  alm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> (secs == alarm) && $past(arm));

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !(w_ctrl && !bus_wdata[4])) |=> alm_flag);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alm_flag || hz_flag));

  // R8
  scratch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !w_scr |=> $stable(scratch));

  // R9
  wrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h00)) |-> bus_rdata[7] && !bus_rdata[1]);

endmodule

bind sec_rtc_core sec_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .run(run_q), .arm(arm_q), .alm_flag(alm_flag_q), .hz_flag(hz_flag_q),
  .secs(secs_q), .alarm(alarm_q), .scratch(scratch_q)
);

// File: tb/tb_sec_rtc_core.sv
module tb_sec_rtc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sec_rtc_core dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference model
  bit          m_en, m_ae, m_aie, m_hie, m_af, m_hf;
  logic [31:0] m_sec, m_alm, m_pre, m_scr;
  longint      m_ph;

  always @(posedge clk) begin
    bit ev_s, ev_a;
    if (!rst_n) begin
      {m_en, m_ae, m_aie, m_hie, m_af, m_hf} = '0;
      m_sec = 0; m_alm = 0; m_pre = 32767; m_scr = 0; m_ph = 0;
    end else begin
      ev_s = 0;
      if (m_en && tick_en) begin
        m_ph = m_ph + 1;
        if (m_ph > longint'(m_pre)) begin
          m_ph = 0; m_sec = m_sec + 1; ev_s = 1;
        end
      end
      ev_a = ev_s && m_ae && (m_sec == m_alm);
      if (bus_wr && bus_addr == 8'h00) begin
        m_en = bus_wdata[0]; m_ae = bus_wdata[2]; m_aie = bus_wdata[3];
        m_hie = bus_wdata[5];
        m_af = (m_af && bus_wdata[4]) || ev_a;
        m_hf = (m_hf && bus_wdata[6]) || ev_s;
      end else begin
        m_af = m_af || ev_a;
        m_hf = m_hf || ev_s;
      end
      if (bus_wr && bus_addr == 8'h04) begin m_sec = bus_wdata; m_ph = 0; end
      if (bus_wr && bus_addr == 8'h08) m_alm = bus_wdata;
      if (bus_wr && bus_addr == 8'h0C) m_pre = bus_wdata;
      if (bus_wr && bus_addr == 8'h34) m_scr = bus_wdata;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return {24'd0, 1'b1, m_hf, m_hie, m_af, m_aie, m_ae, 1'b0, m_en};
      8'h04: return m_sec;
      8'h08: return m_alm;
      8'h0C: return m_pre;
      8'h34: return m_scr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R7: interrupt compared against the model on every clock
  always @(negedge clk) if (rst_n) chk("R7 irq", {31'd0, irq},
    {31'd0, (m_af && m_aie) || (m_hf && m_hie)});

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic rd(string tag, logic [7:0] a);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic rd_const(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_const("R1 ctrl", 8'h00, 32'h80);
    rd_const("R1 secs", 8'h04, 0);
    rd_const("R1 alarm", 8'h08, 0);
    rd_const("R1 presc", 8'h0C, 32'd32767);
    rd_const("R1 scratch", 8'h34, 0);
    // R9 unmapped
    rd_const("R9 unmapped", 8'h10, 0);
    // R8 scratch
    wr(8'h34, 32'h12345678);
    rd_const("R8 scratch", 8'h34, 32'h12345678);
    rd_const("R8 secs untouched", 8'h04, 0);
    // R3 disabled: ticks do nothing
    wr(8'h0C, 2);
    wr(8'h04, 100);
    ticks(5);
    rd_const("R3 hold", 8'h04, 100);
    // R2 R4 counting with 1 Hz irq enabled
    wr(8'h00, 32'h21);
    ticks(2);
    rd_const("R2 not yet", 8'h04, 100);
    ticks(1);
    rd_const("R2 step", 8'h04, 101);
    rd_const("R4 hz flag", 8'h00, 32'hE1);
    // R6 write 1 keeps, write 0 clears
    wr(8'h00, 32'h61);
    rd_const("R6 keep", 8'h00, 32'hE1);
    wr(8'h00, 32'h21);
    rd_const("R6 clear", 8'h00, 32'hA1);
    // R10 seconds write restarts phase
    ticks(2);
    wr(8'h04, 200);
    ticks(2);
    rd_const("R10 no early step", 8'h04, 200);
    ticks(1);
    rd_const("R10 full period", 8'h04, 201);
    // R5 alarm not armed
    wr(8'h08, 202);
    wr(8'h00, 32'h09);
    ticks(3);
    rd_const("R5 unarmed", 8'h00, 32'hC9);
    // R5 armed
    wr(8'h04, 210);
    wr(8'h08, 212);
    wr(8'h00, 32'h0D);
    ticks(3);
    rd("R5 before", 8'h00);
    ticks(3);
    rd_const("R5 hit", 8'h00, 32'hDD);
    rd("R7 ctrl", 8'h00);
    wr(8'h00, 32'h4D);
    rd_const("R6 alarm clear", 8'h00, 32'hCD);
    // R2 wrap
    wr(8'h04, 32'hFFFFFFFF);
    ticks(3);
    rd_const("R2 wrap", 8'h04, 0);
    // R3 phase held while off
    wr(8'h00, 32'h00);
    ticks(1);
    wr(8'h00, 32'h01);
    ticks(1);
    wr(8'h00, 32'h00);
    ticks(4);
    wr(8'h00, 32'h01);
    ticks(1);
    rd("R3 phase", 8'h04);
    ticks(1);
    rd("R3 phase step", 8'h04);
    rd("R8 final", 8'h34);
    rd("R1 presc model", 8'h0C);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule